// File: doc/BRIEF.md
# Four-Source Audio Interrupt Aggregator

This block gathers the FIFO service requests of two audio ports into a single CPU interrupt line. Each port has a playback and a capture direction, which makes four request sources. A source latches into a status register on the rising edge of its request. It reaches the interrupt line only when it is enabled in two separate mask registers. Software clears latched sources one by one with a read-modify-write of the status register. It can also clear all of them at once by driving an interrupt-reset bit low and then high.

A control register carries the soft-reset levels for each port and for the whole block. A rising edge on the whole-block bit returns status, masks and clock enables to their reset values. A separate register gates the clocks of the two ports. All registers sit behind a single-cycle register port, and reads are combinational.

Top module: `audio_irq_hub`

## Requirements
- R1: After reset, status, both masks and the clock-enable register read 0, the control register reads 0x1111, `irq` is 0, and all three soft-reset outputs are 1.
- R2: A 0-to-1 change on `fifo_req[i]` sets status bit i at the next clock edge. Bit 0 is port A playback, bit 1 port A capture, bit 2 port B playback, bit 3 port B capture. A request held high after its bit is cleared does not set the bit again.
- R3: `irq` is high exactly one cycle after some status bit is also set in both the interrupt mask (address 1) and the enable mask (address 2). One mask alone never raises it.
- R4: A write to the status register (address 0) clears every bit written as 0 and leaves every bit written as 1 unchanged. A write never sets a bit.
- R5: In the control register (address 3), a write that takes bit 4 from 0 to 1 clears all status bits. A write of 0 to bit 4, or of 1 to bit 4 when it already holds 1, leaves status unchanged.
- R6: When a request edge and a clear (a status write or an interrupt reset) fall in the same cycle, the status bit of that request ends up set.
- R7: Control bits 8 and 12 drive the port A and port B soft-reset outputs (0 = in reset), and bit 0 drives the block soft-reset output. A write that takes bit 0 from 0 to 1 clears status, both masks and the clock-enable register.
- R8: In the clock-enable register (address 4), bit 0 drives `port_a_clk_en` and bit 4 drives `port_b_clk_en`.
- R9: Register bits without a function read 0, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_req | input | 4 | FIFO service requests, bit order as in R2 |
| cpu_wr | input | 1 | Register write strobe, one cycle |
| cpu_sel | input | 3 | Register address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for `cpu_sel` |
| irq | output | 1 | CPU interrupt line |
| port_a_srst_n | output | 1 | Port A soft reset, active low |
| port_b_srst_n | output | 1 | Port B soft reset, active low |
| blk_srst_n | output | 1 | Whole-block soft reset, active low |
| port_a_clk_en | output | 1 | Port A clock enable |
| port_b_clk_en | output | 1 | Port B clock enable |

## Verification
The bench builds the block with its defaults: four sources, a 16-bit data path and a 3-bit address. These values place every control bit position and every unmapped address inside the tested space. With four sources, one bench run can set several status bits, clear them selectively and mask them one at a time. It can also make a request edge coincide with a clear.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int NSRC = 4;
  localparam int AW   = 3;

  localparam logic [AW-1:0] ADR_STAT  = 3'd0;
  localparam logic [AW-1:0] ADR_IMSK  = 3'd1;
  localparam logic [AW-1:0] ADR_IEMSK = 3'd2;
  localparam logic [AW-1:0] ADR_CTRL  = 3'd3;
  localparam logic [AW-1:0] ADR_CLKEN = 3'd4;

  // control register bit positions (decoded by software and neighbours)
  localparam int CB_BLK  = 0;
  localparam int CB_IRST = 4;
  localparam int CB_PA   = 8;
  localparam int CB_PB   = 12;
  // clock-enable bit positions
  localparam int KB_A = 0;
  localparam int KB_B = 4;

  // index into the packed control state
  typedef enum logic [1:0] {CI_BLK = 2'd0, CI_IRST = 2'd1, CI_PA = 2'd2, CI_PB = 2'd3} ctrl_idx_e;
endpackage

// File: rtl/audio_irq_edge.sv
module audio_irq_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] rise
);
  logic [N-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req;
  end

  assign rise = req & ~req_q;
endmodule

// File: rtl/audio_irq_stat.sv
module audio_irq_stat #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic         wr_stat,
  input  logic [N-1:0] wr_keep,
  input  logic         clr_all,
  output logic [N-1:0] stat_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic keep, en, nxt;

    always_comb begin
      keep = !clr_all && !(wr_stat && !wr_keep[i]);
      en   = rise[i] || wr_stat || clr_all;
      nxt  = (stat_q[i] && keep) || rise[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stat_q[i] <= 1'b0;
      else if (en) stat_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/audio_irq_cfg.sv
module audio_irq_cfg
  import audio_irq_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic [N-1:0]  imsk_q,
  output logic [N-1:0]  iemsk_q,
  output logic [3:0]    ctrl_q,
  output logic [1:0]    clken_q,
  output logic          irst_pulse,
  output logic          blk_pulse
);
  logic       wr_ctrl;
  logic [3:0] ctrl_w;
  logic [N-1:0] imsk_n, iemsk_n;
  logic [3:0] ctrl_n;
  logic [1:0] clken_n;

  always_comb begin
    wr_ctrl = wr && (sel == ADR_CTRL);
    ctrl_w[CI_BLK]  = wdata[CB_BLK];
    ctrl_w[CI_IRST] = wdata[CB_IRST];
    ctrl_w[CI_PA]   = wdata[CB_PA];
    ctrl_w[CI_PB]   = wdata[CB_PB];
    irst_pulse = wr_ctrl && ctrl_w[CI_IRST] && !ctrl_q[CI_IRST];
    blk_pulse  = wr_ctrl && ctrl_w[CI_BLK]  && !ctrl_q[CI_BLK];

    imsk_n  = imsk_q;
    iemsk_n = iemsk_q;
    ctrl_n  = wr_ctrl ? ctrl_w : ctrl_q;
    clken_n = clken_q;
    if (blk_pulse) begin
      imsk_n  = '0;
      iemsk_n = '0;
      clken_n = '0;
    end else if (wr) begin
      if (sel == ADR_IMSK)  imsk_n  = wdata[N-1:0];
      if (sel == ADR_IEMSK) iemsk_n = wdata[N-1:0];
      if (sel == ADR_CLKEN) clken_n = {wdata[KB_B], wdata[KB_A]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imsk_q  <= '0;
      iemsk_q <= '0;
      ctrl_q  <= '1;
      clken_q <= '0;
    end else if (wr) begin
      imsk_q  <= imsk_n;
      iemsk_q <= iemsk_n;
      ctrl_q  <= ctrl_n;
      clken_q <= clken_n;
    end
  end
endmodule

// File: rtl/audio_irq_hub.sv
module audio_irq_hub
  import audio_irq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    fifo_req,
  input  logic          cpu_wr,
  input  logic [2:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq,
  output logic          port_a_srst_n,
  output logic          port_b_srst_n,
  output logic          blk_srst_n,
  output logic          port_a_clk_en,
  output logic          port_b_clk_en
);
  localparam int N = NSRC;

  logic [1:0]   rsync_q;
  logic         rst_sync_n;
  logic [N-1:0] rise, stat_q, imsk_q, iemsk_q;
  logic [3:0]   ctrl_q;
  logic [1:0]   clken_q;
  logic         irst_pulse, blk_pulse, wr_stat, irq_n, irq_q;
  logic         unused_wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  audio_irq_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .req(fifo_req), .rise(rise)
  );

  audio_irq_cfg #(.N(N), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr(cpu_wr), .sel(cpu_sel), .wdata(cpu_wdata),
    .imsk_q(imsk_q), .iemsk_q(iemsk_q), .ctrl_q(ctrl_q), .clken_q(clken_q),
    .irst_pulse(irst_pulse), .blk_pulse(blk_pulse)
  );

  assign wr_stat = cpu_wr && (cpu_sel == ADR_STAT);

  audio_irq_stat #(.N(N)) u_stat (
    .clk(clk), .rst_n(rst_sync_n), .rise(rise), .wr_stat(wr_stat),
    .wr_keep(cpu_wdata[N-1:0]), .clr_all(irst_pulse || blk_pulse), .stat_q(stat_q)
  );

  assign irq_n = |(stat_q & imsk_q & iemsk_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_n;
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_sel)
      ADR_STAT:  cpu_rdata[N-1:0] = stat_q;
      ADR_IMSK:  cpu_rdata[N-1:0] = imsk_q;
      ADR_IEMSK: cpu_rdata[N-1:0] = iemsk_q;
      ADR_CTRL: begin
        cpu_rdata[CB_BLK]  = ctrl_q[CI_BLK];
        cpu_rdata[CB_IRST] = ctrl_q[CI_IRST];
        cpu_rdata[CB_PA]   = ctrl_q[CI_PA];
        cpu_rdata[CB_PB]   = ctrl_q[CI_PB];
      end
      ADR_CLKEN: begin
        cpu_rdata[KB_A] = clken_q[0];
        cpu_rdata[KB_B] = clken_q[1];
      end
      default: cpu_rdata = '0;
    endcase
  end

  assign unused_wdata  = ^cpu_wdata;
  assign irq           = irq_q;
  assign blk_srst_n    = ctrl_q[CI_BLK];
  assign port_a_srst_n = ctrl_q[CI_PA];
  assign port_b_srst_n = ctrl_q[CI_PB];
  assign port_a_clk_en = clken_q[0];
  assign port_b_clk_en = clken_q[1];
endmodule

// File: rtl/audio_irq_hub_chk.sv
module audio_irq_hub_chk #(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  fifo_req,
  input logic [N-1:0]  stat_q,
  input logic [N-1:0]  imsk_q,
  input logic [N-1:0]  iemsk_q,
  input logic          irq,
  input logic          cpu_wr,
  input logic [2:0]    cpu_sel,
  input logic [DW-1:0] cpu_wdata,
  input logic          port_a_clk_en,
  input logic          port_b_clk_en
);
  logic [N-1:0] req_d, edge_d, stat_d;
  logic         src_d, b4_seen, irst_d, wr_d;
  logic         irst_c;

  assign irst_c = cpu_wr && (cpu_sel == 3'd3) && cpu_wdata[4] && !b4_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= '0; edge_d <= '0; stat_d <= '0; src_d <= 1'b0;
      b4_seen <= 1'b1; irst_d <= 1'b0; wr_d <= 1'b0;
    end else begin
      req_d  <= fifo_req;
      edge_d <= fifo_req & ~req_d;
      stat_d <= stat_q;
      src_d  <= |(stat_q & imsk_q & iemsk_q);
      if (cpu_wr && cpu_sel == 3'd3) b4_seen <= cpu_wdata[4];
      irst_d <= irst_c;
      wr_d   <= cpu_wr;
    end
  end

  assert_edge_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & edge_d) == edge_d);

  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~stat_d & ~edge_d) == '0);

  assert_irq_both_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq == src_d);

  assert_irst_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irst_d |-> ((stat_q & ~edge_d) == '0));

  assert_clken_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_d |-> ($stable(port_a_clk_en) && $stable(port_b_clk_en)));
endmodule

bind audio_irq_hub audio_irq_hub_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .fifo_req(fifo_req), .stat_q(stat_q),
  .imsk_q(imsk_q), .iemsk_q(iemsk_q), .irq(irq), .cpu_wr(cpu_wr),
  .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
  .port_a_clk_en(port_a_clk_en), .port_b_clk_en(port_b_clk_en)
);

// File: tb/audio_irq_hub_tb.sv
module audio_irq_hub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fifo_req = '0;
  logic        cpu_wr = 1'b0;
  logic [2:0]  cpu_sel = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        irq, port_a_srst_n, port_b_srst_n, blk_srst_n, port_a_clk_en, port_b_clk_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_req(fifo_req), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .port_a_srst_n(port_a_srst_n), .port_b_srst_n(port_b_srst_n), .blk_srst_n(blk_srst_n),
    .port_a_clk_en(port_a_clk_en), .port_b_clk_en(port_b_clk_en)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cpu_sel = a; cpu_wdata = d; cpu_wr = 1'b1;
    step();
    cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    cpu_sel = a;
    #0.5;
    d = cpu_rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    fifo_req = m; step(); fifo_req = '0; step();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(0, d); chk("R1 status", d, 16'h0);
    rd(1, d); chk("R1 imask", d, 16'h0);
    rd(2, d); chk("R1 iemask", d, 16'h0);
    rd(3, d); chk("R1 ctrl", d, 16'h1111);
    rd(4, d); chk("R1 clken", d, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 srst outs", {13'd0, port_b_srst_n, port_a_srst_n, blk_srst_n}, 16'h7);
  endtask

  task automatic t_latch();
    logic [15:0] d;
    fifo_req = 4'b0101; step();
    rd(0, d); chk("R2 rise sets A-play/B-play", d, 16'h5);
    step();
    rd(0, d); chk("R2 held level keeps", d, 16'h5);
    wr(0, 16'h0);
    step();
    rd(0, d); chk("R2 held level no re-set", d, 16'h0);
    fifo_req = '0; step();
    pulse(4'b1010);
    rd(0, d); chk("R2 rise sets A-cap/B-cap", d, 16'hA);
    wr(0, 16'h0);
  endtask

  task automatic t_masks();
    pulse(4'b0010);
    wr(1, 16'h2); step();
    chk("R3 imask alone", {15'd0, irq}, 16'h0);
    wr(1, 16'h0); wr(2, 16'h2); step();
    chk("R3 iemask alone", {15'd0, irq}, 16'h0);
    wr(1, 16'h2);
    chk("R3 one-cycle lag", {15'd0, irq}, 16'h0);
    step();
    chk("R3 both masks", {15'd0, irq}, 16'h1);
    wr(0, 16'h0);
    chk("R3 lag on clear", {15'd0, irq}, 16'h1);
    step();
    chk("R3 drops after clear", {15'd0, irq}, 16'h0);
    wr(1, 16'h0); wr(2, 16'h0);
  endtask

  task automatic t_keep();
    logic [15:0] d;
    pulse(4'hF);
    wr(0, 16'hFFFE);
    rd(0, d); chk("R4 zero clears one bit", d, 16'hE);
    wr(0, 16'hFFFF);
    rd(0, d); chk("R4 one never sets", d, 16'hE);
    wr(0, 16'h0);
  endtask

  task automatic t_win();
    logic [15:0] d;
    pulse(4'b0110);
    fifo_req = 4'b0001;
    wr(0, 16'h0);
    rd(0, d); chk("R6 edge beats status write", d, 16'h1);
    fifo_req = '0; step();
    wr(0, 16'h0);
    wr(3, 16'h1101);
    fifo_req = 4'b1000;
    wr(3, 16'h1111);
    rd(0, d); chk("R6 edge beats irq reset", d, 16'h8);
    fifo_req = '0; step();
    wr(0, 16'h0);
  endtask

  task automatic t_irst();
    logic [15:0] d;
    pulse(4'b1001);
    wr(3, 16'h1101);
    rd(0, d); chk("R5 bit4 low keeps status", d, 16'h9);
    wr(1, 16'hF); wr(2, 16'hF); step();
    chk("R5 irq pending", {15'd0, irq}, 16'h1);
    wr(3, 16'h1111);
    rd(0, d); chk("R5 low-high clears", d, 16'h0);
    step();
    chk("R5 irq cleared", {15'd0, irq}, 16'h0);
    pulse(4'b0011);
    wr(3, 16'h1111);
    rd(0, d); chk("R5 high-high keeps", d, 16'h3);
    wr(0, 16'h0); wr(1, 16'h0); wr(2, 16'h0); step();
  endtask

  task automatic t_soft();
    logic [15:0] d;
    wr(3, 16'h0111);
    chk("R7 port B reset", {14'd0, port_b_srst_n, port_a_srst_n}, 16'h1);
    wr(3, 16'h1011);
    chk("R7 port A reset", {14'd0, port_b_srst_n, port_a_srst_n}, 16'h2);
    wr(3, 16'h1111);
    wr(4, 16'h0011); wr(1, 16'hF); wr(2, 16'hF); pulse(4'b0100);
    wr(3, 16'h1110);
    chk("R7 block reset low", {15'd0, blk_srst_n}, 16'h0);
    rd(1, d); chk("R7 masks kept while low", d, 16'hF);
    wr(3, 16'h1111);
    rd(0, d); chk("R7 block rise clears status", d, 16'h0);
    rd(1, d); chk("R7 block rise clears imask", d, 16'h0);
    rd(2, d); chk("R7 block rise clears iemask", d, 16'h0);
    rd(4, d); chk("R7 block rise clears clken", d, 16'h0);
    step();
    chk("R7 irq low", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_clken();
    wr(4, 16'h0010);
    chk("R8 B only", {14'd0, port_b_clk_en, port_a_clk_en}, 16'h2);
    wr(4, 16'h0001);
    chk("R8 A only", {14'd0, port_b_clk_en, port_a_clk_en}, 16'h1);
    wr(4, 16'h0000);
    chk("R8 none", {14'd0, port_b_clk_en, port_a_clk_en}, 16'h0);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    wr(4, 16'hFFFF); rd(4, d); chk("R9 clken unused bits", d, 16'h0011);
    wr(1, 16'hFFFF); rd(1, d); chk("R9 imask unused bits", d, 16'h000F);
    wr(3, 16'hFFFF); rd(3, d); chk("R9 ctrl unused bits", d, 16'h1111);
    rd(5, d); chk("R9 addr 5", d, 16'h0);
    rd(7, d); chk("R9 addr 7", d, 16'h0);
    wr(1, 16'h0); wr(4, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch();
    t_masks();
    t_keep();
    t_win();
    t_irst();
    t_soft();
    t_clken();
    t_readback();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule